// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical memory address by combining it with one of six 16-bit segment base registers. The chosen segment value is multiplied by sixteen (a four-bit left shift) and the offset is added. Any carry past the top address bit is dropped, so the address space of 00000h to FFFFFh wraps around.

The caller gives a small access-type code that says which kind of register produced the offset: instruction pointer, stack pointer, frame pointer, an offset taken directly from the instruction, a base register, or a string source or destination index. From that code the block picks a default segment. An override request can replace the default. Two segments, instruction fetch and string destination writes, are fixed and cannot be overridden. The two additional extra segments are never chosen by default, so they can only be reached through an override.

Segment registers are loaded through a synchronous write port. The address and the selected segment index are computed combinationally from the stored register values and the current request inputs.

Top module: `seg_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears all six segment registers to zero. After reset, `phys_addr` equals the zero-extended offset for every access type.
- R2: A write with `wr_en`=1 and `wr_idx`<6 loads `wr_data` into that segment register at the rising clock edge. The address output does not change before that edge.
- R3: A write with `wr_idx` of 6 or 7 changes no segment register.
- R4: `phys_addr` = (segment × 16 + offset) mod 2^20. For example, segment FFFFh with offset FFFFh gives 0FFEFh.
- R5: Segment indices are: 0 code, 1 data, 2 stack, 3 extra, 4 second extra, 5 third extra. `seg_sel` always reports the index that was used.
- R6: Access type 0 (instruction fetch) always uses segment 0, even when an override is requested.
- R7: Access types 1 (stack pointer) and 2 (frame pointer) use segment 2 by default.
- R8: Access types 3 (direct offset), 4 (base register), 5 (string source) and 7 (spare) use segment 1 by default.
- R9: Access type 6 (string destination) always uses segment 3, even when an override is requested.
- R10: When `ovr_valid`=1 and `ovr_seg`<6, the override replaces the default segment for access types 1 to 5 and 7.
- R11: An override whose `ovr_seg` is 6 or 7 is ignored, and the default segment is used.
- R12: With no valid override, segments 4 and 5 are never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write enable |
| wr_idx | input | 3 | Index of the segment register to write |
| wr_data | input | 16 | Value to load |
| acc_type | input | 3 | Kind of register that supplied the offset |
| ovr_valid | input | 1 | Request a segment override |
| ovr_seg | input | 3 | Segment index used for the override |
| offset | input | 16 | Effective offset |
| phys_addr | output | 20 | Physical address |
| seg_sel | output | 3 | Index of the segment actually used |

## Verification
All six segments are loaded with distinct values, so a wrong segment choice shows up as a wrong address as well as a wrong index. Each of the eight access types is driven with no override, with an in-range override and with an out-of-range override; this separates the default mapping from the override path and from the two fixed cases. Writes to indices 6 and 7, and a sample taken before the write edge, expose decode and timing faults. A maximal segment paired with a maximal offset shows whether the carry past bit 19 is dropped.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int IDX_W = 3;
  localparam int ACC_W = 3;

  typedef enum logic [ACC_W-1:0] {
    ACC_FETCH  = 3'd0,
    ACC_SP     = 3'd1,
    ACC_BP     = 3'd2,
    ACC_DIRECT = 3'd3,
    ACC_BASE   = 3'd4,
    ACC_SRC    = 3'd5,
    ACC_DST    = 3'd6,
    ACC_SPARE  = 3'd7
  } acc_t;

  localparam logic [IDX_W-1:0] SEG_CODE  = 3'd0;
  localparam logic [IDX_W-1:0] SEG_DATA  = 3'd1;
  localparam logic [IDX_W-1:0] SEG_STACK = 3'd2;
  localparam logic [IDX_W-1:0] SEG_EXTRA = 3'd3;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEG_W-1:0] rd_data
);
  logic [SEG_W-1:0] seg_q [NSEG];

  generate
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
      always_ff @(posedge clk) begin
        if (rst)
          seg_q[g] <= '0;
        else if (wr_en && (wr_idx == IDX_W'(g)))
          seg_q[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSEG; i++)
      if (rd_idx == IDX_W'(i)) rd_data = seg_q[i];
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int NSEG = 6
) (
  input  logic [ACC_W-1:0] acc_type,
  input  logic             ovr_valid,
  input  logic [IDX_W-1:0] ovr_seg,
  output logic [IDX_W-1:0] sel
);
  logic [IDX_W-1:0] dflt;
  logic             fixed;
  logic             ovr_ok;

  always_comb begin
    fixed = 1'b0;
    unique case (acc_t'(acc_type))
      ACC_FETCH: begin dflt = SEG_CODE;  fixed = 1'b1; end
      ACC_SP,
      ACC_BP:    dflt = SEG_STACK;
      ACC_DST:   begin dflt = SEG_EXTRA; fixed = 1'b1; end
      default:   dflt = SEG_DATA;
    endcase
  end

  assign ovr_ok = ovr_valid && (ovr_seg < IDX_W'(NSEG)) && !fixed;
  assign sel    = ovr_ok ? ovr_seg : dflt;
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] off_w;

  assign base_w = {seg, {SHIFT{1'b0}}};
  assign off_w  = {{(ADDR_W-OFF_W){1'b0}}, off};
  assign addr   = base_w + off_w;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG  = 6,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic [ACC_W-1:0]  acc_type,
  input  logic              ovr_valid,
  input  logic [IDX_W-1:0]  ovr_seg,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [IDX_W-1:0]  seg_sel
);
  logic [SEG_W-1:0] seg_val;

  seg_select #(.NSEG(NSEG)) u_sel (
    .acc_type (acc_type),
    .ovr_valid(ovr_valid),
    .ovr_seg  (ovr_seg),
    .sel      (seg_sel)
  );

  seg_regfile #(.SEG_W(SEG_W), .NSEG(NSEG), .IDX_W(IDX_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_idx (seg_sel),
    .rd_data(seg_val)
  );

  addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
    .seg (seg_val),
    .off (offset),
    .addr(phys_addr)
  );
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int SHIFT  = 4,
  parameter int NSEG   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        acc_type,
  input logic              ovr_valid,
  input logic [2:0]        ovr_seg,
  input logic [OFF_W-1:0]  offset,
  input logic [ADDR_W-1:0] phys_addr,
  input logic [2:0]        seg_sel
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> phys_addr == ADDR_W'(offset));

  // R4
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    phys_addr[SHIFT-1:0] == offset[SHIFT-1:0]);

  // R5
  sel_range_chk: assert property (@(posedge clk) disable iff (rst)
    seg_sel < 3'(NSEG));

  // R6
  fetch_seg_chk: assert property (@(posedge clk) disable iff (rst)
    acc_type == 3'd0 |-> seg_sel == 3'd0);

  // R9
  dst_seg_chk: assert property (@(posedge clk) disable iff (rst)
    acc_type == 3'd6 |-> seg_sel == 3'd3);

  // R10
  ovr_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_valid && ovr_seg < 3'(NSEG) && acc_type != 3'd0 && acc_type != 3'd6)
      |-> seg_sel == ovr_seg);

  // R12
  hidden_seg_chk: assert property (@(posedge clk) disable iff (rst)
    !ovr_valid |-> seg_sel < 3'd4);
endmodule

bind seg_addr_gen seg_addr_chk #(.OFF_W(OFF_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT), .NSEG(NSEG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_type (acc_type),
  .ovr_valid(ovr_valid),
  .ovr_seg  (ovr_seg),
  .offset   (offset),
  .phys_addr(phys_addr),
  .seg_sel  (seg_sel)
);

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [15:0] wr_data;
  logic [2:0]  acc_type;
  logic        ovr_valid;
  logic [2:0]  ovr_seg;
  logic [15:0] offset;
  logic [19:0] phys_addr;
  logic [2:0]  seg_sel;

  int errors = 0;
  int checks = 0;
  logic [15:0] model [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .acc_type(acc_type), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .offset(offset), .phys_addr(phys_addr), .seg_sel(seg_sel)
  );

  function automatic logic [2:0] exp_sel(input logic [2:0] t, input logic ov, input logic [2:0] os);
    logic [2:0] d;
    if (t == 3'd0) return 3'd0;
    if (t == 3'd6) return 3'd3;
    d = (t == 3'd1 || t == 3'd2) ? 3'd2 : 3'd1;
    if (ov && os < 3'd6) return os;
    return d;
  endfunction

  function automatic logic [19:0] exp_addr(input logic [2:0] s, input logic [15:0] off);
    logic [20:0] full;
    full = {1'b0, model[s], 4'h0} + {5'h0, off};
    return full[19:0];
  endfunction

  task automatic chk(input string req, input logic [19:0] ea, input logic [2:0] es);
    checks++;
    if (phys_addr !== ea || seg_sel !== es) begin
      errors++;
      $display("FAIL %s: addr=%h sel=%0d expected addr=%h sel=%0d", req, phys_addr, seg_sel, ea, es);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] t, input logic ov,
                       input logic [2:0] os, input logic [15:0] off);
    logic [2:0] es;
    acc_type = t; ovr_valid = ov; ovr_seg = os; offset = off;
    #1;
    es = exp_sel(t, ov, os);
    chk(req, exp_addr(es, off), es);
  endtask

  task automatic write_seg(input logic [2:0] idx, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < 3'd6) model[idx] = v;
  endtask

  // R1: everything reads as zero after reset
  task automatic t_reset;
    for (int t = 0; t < 8; t++) begin
      apply("R1", 3'(t), 1'b0, 3'd0, 16'h1234 + 16'(t));
      checks++;
      if (phys_addr !== 20'h01234 + 20'(t)) begin
        errors++;
        $display("FAIL R1: addr=%h expected %h", phys_addr, 20'h01234 + 20'(t));
      end
    end
  endtask

  // R2: writes land on the edge, not before
  task automatic t_write_timing;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd1; wr_data = 16'hA5A5;
    apply("R2 before edge", 3'd3, 1'b0, 3'd0, 16'h0010);
    @(negedge clk);
    wr_en = 1'b0;
    model[1] = 16'hA5A5;
    apply("R2 after edge", 3'd3, 1'b0, 3'd0, 16'h0010);
  endtask

  // R5, R10: load all six and read each back through an override
  task automatic t_all_segments;
    for (int i = 0; i < 6; i++) write_seg(3'(i), 16'h1000 * 16'(i + 1) + 16'h0111 * 16'(i));
    for (int i = 0; i < 6; i++) apply("R10 override read", 3'd3, 1'b1, 3'(i), 16'h0042);
  endtask

  // R3: out-of-range writes are dropped
  task automatic t_bad_write;
    write_seg(3'd6, 16'hDEAD);
    write_seg(3'd7, 16'hBEEF);
    for (int i = 0; i < 6; i++) apply("R3", 3'd5, 1'b1, 3'(i), 16'h0007);
  endtask

  // R6 R7 R8 R9 R12: default mapping, no override
  task automatic t_defaults;
    apply("R6", 3'd0, 1'b0, 3'd0, 16'h0100);
    apply("R7 sp", 3'd1, 1'b0, 3'd0, 16'hFFFE);
    apply("R7 bp", 3'd2, 1'b0, 3'd0, 16'h0020);
    apply("R8 direct", 3'd3, 1'b0, 3'd0, 16'h0300);
    apply("R8 base", 3'd4, 1'b0, 3'd0, 16'h0400);
    apply("R8 src", 3'd5, 1'b0, 3'd0, 16'h0500);
    apply("R9", 3'd6, 1'b0, 3'd0, 16'h0600);
    apply("R8 spare", 3'd7, 1'b0, 3'd0, 16'h0700);
  endtask

  // R6 R9 R10: fixed types ignore override, others take it
  task automatic t_override;
    for (int t = 0; t < 8; t++) apply("R10/R6/R9 ovr", 3'(t), 1'b1, 3'd4, 16'h0ABC);
    for (int t = 0; t < 8; t++) apply("R10/R6/R9 ovr", 3'(t), 1'b1, 3'd5, 16'h1001);
  endtask

  // R11: bad override index ignored
  task automatic t_bad_override;
    for (int t = 0; t < 8; t++) apply("R11", 3'(t), 1'b1, 3'd6, 16'h0055);
    apply("R11", 3'd2, 1'b1, 3'd7, 16'h0066);
  endtask

  // R4: wrap past bit 19
  task automatic t_wrap;
    write_seg(3'd2, 16'hFFFF);
    apply("R4 wrap", 3'd1, 1'b0, 3'd0, 16'hFFFF);
    checks++;
    if (phys_addr !== 20'h0FFEF) begin
      errors++;
      $display("FAIL R4: addr=%h expected 0ffef", phys_addr);
    end
    write_seg(3'd0, 16'hF000);
    apply("R4 top", 3'd0, 1'b0, 3'd0, 16'h0FFF);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) model[i] = '0;
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    acc_type = '0; ovr_valid = 1'b0; ovr_seg = '0; offset = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_timing();
    t_all_segments();
    t_bad_write();
    t_defaults();
    t_override();
    t_bad_override();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule